// File: doc/BRIEF.md
# Dual-Channel Serial DAC Load Interface

This block is the digital front end of a two-channel, 12-bit serial-input converter, modelled synchronously. A fast system clock samples four slow pins (active-low select, serial clock, serial data and an active-low load strobe). It shifts the incoming bits into a 24-bit frame register. Under the select and load rules it copies that frame into two 12-bit output codes, one per channel. The analog conversion is not part of the block.

A 24-bit frame carries both channels, with channel B first. The bit from 24 serial clocks back leaves on an open-drain data output. Several devices can then be chained, and a host can read back what it wrote. With the load strobe tied low, a frame takes effect when select rises. With the strobe idling high, it takes effect when the strobe falls while the device is deselected.

Top module: `dual_dac_loader`

## Requirements
- R1: While `rst` is high, both codes are cleared to zero, the frame register clears to zero and the serial output pulls nothing low.
- R2: While `cs_n` is low, each rising `sclk` edge shifts `sdi` into bit 0 of the frame register, so the first bit ends up in bit 23. Bits 23..12 become `code_b` and bits 11..0 become `code_a`.
- R3: `sclk` edges while `cs_n` is high do not alter the frame register.
- R4: The serial output carries frame bit 23. It takes that bit when `cs_n` falls and again on every falling `sclk` edge while `cs_n` is low. The result is that each bit reappears 24 clocks after it entered, previous frame first.
- R5: `sdo_en` is high only while `cs_n` is low. `sdo_pull` is high only when `sdo_en` is high and the output bit is 0 (open-drain: it can only pull low).
- R6: With `load_n` held low, both codes take the frame when `cs_n` rises.
- R7: With `load_n` idling high, a rise of `cs_n` changes no code. A later fall of `load_n` while `cs_n` is high loads both codes together.
- R8: `load_n` going low while `cs_n` is low changes no code. The load happens once `cs_n` rises if `load_n` is still low.
- R9: A frame shorter than 24 bits is not rejected. The codes take whatever the frame register holds at the load.
- R10: The frame register keeps its contents while `cs_n` is high, so the next frame's serial output replays them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low device select (asynchronous pin) |
| sclk | input | 1 | Serial clock (asynchronous pin) |
| sdi | input | 1 | Serial data in |
| load_n | input | 1 | Active-low load strobe (asynchronous pin) |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |
| sdo_pull | output | 1 | Open-drain pull-low enable for the serial output |
| sdo_en | output | 1 | Serial output enabled (low means high impedance) |

## Verification
Every pin goes through two synchronizer flops before any logic sees it. `sdo_en` therefore follows `cs_n` after two system clocks. The serial-output bit, the frame register and both codes follow their triggering pin edge after three. The bench holds every pin for five system clocks and samples outputs on the falling system-clock edge, four or five clocks after the triggering pin change. That lands past the three-cycle latency and before the next stimulus. Each serial-output sample is taken after a falling `sclk` and compared with bit 23 of a bench-side copy of the frame register.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    localparam int CODE_W_DEF = 12;
    localparam int SYNC_DEF   = 2;

    // Sampled pin bundle, carried through the synchronizer as one word
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic din;
        logic ld_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, din: 1'b0, ld_n: 1'b1};

    function automatic logic is_rise(input logic now_v, input logic old_v);
        return now_v & ~old_v;
    endfunction

    function automatic logic is_fall(input logic now_v, input logic old_v);
        return ~now_v & old_v;
    endfunction

endpackage

// File: rtl/dacld_sync.sv
module dacld_sync
    import dacld_pkg::*;
#(
    parameter int STAGES = SYNC_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t raw,
    output pins_t cur
);
    pins_t chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[g] <= PINS_IDLE;
                else if (g == 0)
                    chain[g] <= raw;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign cur = chain[STAGES-1];
endmodule

// File: rtl/dacld_shift.sv
module dacld_shift
    import dacld_pkg::*;
#(
    parameter int FRAME_W = 2 * CODE_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               din,
    output logic [FRAME_W-1:0] frame,
    output logic               dout_bit,
    output logic               dout_oe
);
    logic sclk_d, cs_d;
    logic active, sclk_rise, sclk_fall, cs_fall;

    assign active    = ~cs_n;
    assign sclk_rise = is_rise(sclk, sclk_d);
    assign sclk_fall = is_fall(sclk, sclk_d);
    assign cs_fall   = is_fall(cs_n, cs_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            cs_d     <= 1'b1;
            frame    <= '0;
            dout_bit <= 1'b1;
        end else begin
            sclk_d <= sclk;
            cs_d   <= cs_n;
            if (active && sclk_rise)
                frame <= {frame[FRAME_W-2:0], din};
            if (cs_fall || (active && sclk_fall))
                dout_bit <= frame[FRAME_W-1];
        end
    end

    assign dout_oe = active;

    AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(frame)); // R3

    AST_DOUT_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout_bit) |-> $past(!cs_n)); // R4
endmodule

// File: rtl/dacld_latch.sv
module dacld_latch
    import dacld_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                ld_n,
    input  logic [2*CODE_W-1:0] frame,
    output logic [CODE_W-1:0]   code_a,
    output logic [CODE_W-1:0]   code_b
);
    logic upd;

    // Level rule: deselected with load low; covers both wiring modes
    assign upd = cs_n & ~ld_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_a <= '0;
            code_b <= '0;
        end else if (upd) begin
            code_b <= frame[2*CODE_W-1:CODE_W];
            code_a <= frame[CODE_W-1:0];
        end
    end

    AST_HOLD_WHILE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> $stable({code_b, code_a})); // R8

    AST_HOLD_LOAD_HIGH: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> $stable({code_b, code_a})); // R7
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dacld_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    parameter int SYNC_N = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              load_n,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              sdo_pull,
    output logic              sdo_en
);
    localparam int FRAME_W = 2 * CODE_W;

    pins_t raw, cur;
    logic [FRAME_W-1:0] frame;
    logic dout_bit;

    assign raw = '{cs_n: cs_n, sclk: sclk, din: sdi, ld_n: load_n};

    dacld_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .raw(raw), .cur(cur)
    );

    dacld_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst(rst), .cs_n(cur.cs_n), .sclk(cur.sclk), .din(cur.din),
        .frame(frame), .dout_bit(dout_bit), .dout_oe(sdo_en)
    );

    dacld_latch #(.CODE_W(CODE_W)) u_latch (
        .clk(clk), .rst(rst), .cs_n(cur.cs_n), .ld_n(cur.ld_n), .frame(frame),
        .code_a(code_a), .code_b(code_b)
    );

    assign sdo_pull = sdo_en & ~dout_bit;

    AST_CODES_MOVE_TOGETHER_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        (!$stable(code_a) || !$stable(code_b)) |-> $past(cur.cs_n)); // R6
endmodule

// File: tb/dual_dac_loader_test.sv
module dual_dac_loader_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1;
    logic [11:0] code_a, code_b;
    logic sdo_pull, sdo_en;

    int checks = 0;
    int fails  = 0;
    logic [23:0] model = '0;
    logic [11:0] exp_a = '0, exp_b = '0;

    always #5 clk = ~clk;

    dual_dac_loader uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .load_n(load_n),
        .code_a(code_a), .code_b(code_b), .sdo_pull(sdo_pull), .sdo_en(sdo_en)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] hi_code(input logic [23:0] f);
        return f[23:12];
    endfunction

    function automatic logic [11:0] lo_code(input logic [23:0] f);
        return f[11:0];
    endfunction

    task automatic chk_codes(input string req);
        chk({req, " code_b"}, {20'd0, code_b}, {20'd0, exp_b});
        chk({req, " code_a"}, {20'd0, code_a}, {20'd0, exp_a});
    endtask

    // Selects the device and shifts n bits of val, MSB first; checks readback per bit (R4, R10)
    task automatic shift_frame(input logic [23:0] val, input int n);
        cs_n = 1'b0;
        step(5);
        chk("R5 sdo_en while selected", {31'd0, sdo_en}, 32'd1);
        chk("R4 first readback bit at select", {31'd0, sdo_pull}, {31'd0, ~model[23]});
        for (int i = 0; i < n; i++) begin
            sdi = val[n-1-i];
            step(5);
            sclk = 1'b1;
            model = {model[22:0], val[n-1-i]};
            step(5);
            sclk = 1'b0;
            step(4);
            chk("R4 readback after falling sclk", {31'd0, sdo_pull}, {31'd0, ~model[23]});
            step(1);
        end
        chk_codes("R8 codes hold while selected");
    endtask

    task automatic end_three_wire();
        load_n = 1'b0;
        step(5);
        chk_codes("R8 no load while selected");
        cs_n = 1'b1;
        step(5);
        exp_b = hi_code(model);
        exp_a = lo_code(model);
        chk_codes("R6 load on select rise");
        chk("R5 released when deselected", {30'd0, sdo_en, sdo_pull}, 32'd0);
    endtask

    task automatic end_four_wire();
        load_n = 1'b1;
        cs_n = 1'b1;
        step(5);
        chk_codes("R7 no load at select rise");
        load_n = 1'b0;
        step(5);
        exp_b = hi_code(model);
        exp_a = lo_code(model);
        chk_codes("R7 load on strobe fall");
        load_n = 1'b1;
        step(5);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [23:0] v;
        void'($urandom(32'h00c0ffee));
        step(5);
        chk_codes("R1 reset codes");
        chk("R1 reset output", {30'd0, sdo_en, sdo_pull}, 32'd0);
        rst = 1'b0;
        step(3);

        // R2: directed frame, channel B first
        shift_frame(24'hABC123, 24);
        end_three_wire();
        chk("R2 channel B field", {20'd0, code_b}, 32'h0ABC);
        chk("R2 channel A field", {20'd0, code_a}, 32'h0123);

        // R7: four-wire update
        shift_frame(24'h5A0F3C, 24);
        end_four_wire();

        // R3: clocks while deselected are ignored; strobe shows register unchanged
        for (int i = 0; i < 6; i++) begin
            sdi = i[0];
            step(5); sclk = 1'b1; step(5); sclk = 1'b0;
        end
        load_n = 1'b0;
        step(5);
        chk_codes("R3 register untouched by deselected clocks");
        load_n = 1'b1;
        step(5);

        // R8: strobe during selection waits for select rise
        shift_frame(24'h13579B, 24);
        load_n = 1'b0;
        step(6);
        chk_codes("R8 strobe while selected ignored");
        cs_n = 1'b1;
        step(5);
        exp_b = hi_code(model);
        exp_a = lo_code(model);
        chk_codes("R8 load at select rise");
        load_n = 1'b1;
        step(5);

        // R9: short frame, 8 bits, then R10 replay on next frame
        shift_frame(24'h0000A5, 8);
        end_three_wire();
        chk("R9 short frame code_a", {20'd0, code_a}, {20'd0, lo_code(model)});
        load_n = 1'b1;

        // Random frames with mixed modes and lengths
        for (int k = 0; k < 30; k++) begin
            v = 24'($urandom());
            if ($urandom_range(0, 3) == 0)
                shift_frame(v, int'($urandom_range(1, 23)));
            else
                shift_frame(v, 24);
            if ($urandom_range(0, 1) == 1) begin
                end_three_wire();
                load_n = 1'b1;
                step(3);
            end else begin
                end_four_wire();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule